// File: doc/BRIEF.md
# Clock-Enable Divider Bank with Synchronized Ratio Update

This block turns one source clock into up to nine clock-enable streams. Each stream comes from its own divider. Each divider emits a one-cycle pulse once every (ratio + 1) source cycles, and its output can be held off by an enable bit. The outputs are enables for logic running on the source clock; they are not generated clocks.

Software programs the ratios through a simple single-cycle register bus. A ratio write only stages a pending value. The new ratios take effect in every divider at the same edge, and only after software writes the go command. At that edge every counter restarts, so all streams begin from a common phase. A busy flag in a status register stays set from the accepted go command until the transfer has completed. Software polls it before staging new ratios and again after each go. The enable bits are not staged and act directly.

Top module: `clkdiv_bank`

## Requirements
- R1: After reset the busy flag (status offset 0x13C, bit 0) reads 0. Every divider register reads 0x0000_8000 (enabled, ratio 0), and every divider output is high in every cycle.
- R2: Divider registers 1 to 3 sit at offsets 0x118, 0x11C and 0x120. Dividers 4 to 9 sit at 0x160, 0x164, 0x168, 0x16C, 0x170 and 0x174. In each divider register, bits [4:0] hold the ratio and bit 15 holds the enable. A read returns the staged ratio and the enable, with all other bits 0.
- R3: An enabled divider with active ratio r is high for exactly one cycle in every r+1 cycles.
- R4: A ratio write changes only the staged value. The active division is unchanged until a go command transfers it. A transfer takes the staged value held before the transfer edge, even if a ratio write lands at that same edge.
- R5: Writing 1 to bit 0 of the command register (offset 0x138) while idle sets busy at that write edge (edge E0). At the next edge (E1) all staged ratios become active and all counters restart at 0. Busy reads 0 after the edge that follows (E2).
- R6: A go write while busy is set has no effect: busy still clears after E2 and stays clear. The command register always reads 0.
- R7: With the enable bit at 0 a divider holds its output low but keeps its ratio. Setting the enable again, without a go command, resumes pulsing at the stored ratio.
- R8: Reads from unmapped offsets return 0. Writes to unmapped offsets change no register, start no update and leave busy clear.
- R9: After a transfer at E1, a divider with ratio r first pulses r cycles after E1, so all dividers share a common phase origin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Source clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_req_i | input | 1 | Bus access strobe, one cycle per access |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 12 | Byte offset of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i, combinational |
| div_tick_o | output | 9 | Clock-enable pulse of each divider (bit 0 = divider 1) |

## Verification
The transfer edge is where two functions collide. On that edge the bus may carry either a second go command or a new ratio write, at the same time as the active ratios are loaded. The bench places a go write and, in another run, a divider write exactly on the edge after an accepted go.

It then judges the result at the ports. Busy must clear on schedule and not re-arm. The measured period must match the ratio staged before the collision, while the readback shows the new value, which only a later go applies.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  localparam int unsigned ADDR_W   = 12;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned EN_BIT   = 15;
  localparam int unsigned LO_CNT   = 3;      // dividers in the lower window
  localparam logic [ADDR_W-1:0] LO_BASE  = 12'h118;
  localparam logic [ADDR_W-1:0] HI_BASE  = 12'h160;
  localparam logic [ADDR_W-1:0] CMD_ADDR = 12'h138;
  localparam logic [ADDR_W-1:0] STA_ADDR = 12'h13C;

  // split map: first LO_CNT dividers low, the rest in the upper window
  function automatic logic [ADDR_W-1:0] div_addr(input int unsigned idx);
    if (idx < LO_CNT) return LO_BASE + ADDR_W'(4 * idx);
    else              return HI_BASE + ADDR_W'(4 * (idx - LO_CNT));
  endfunction
endpackage

// File: rtl/clkdiv_regs.sv
module clkdiv_regs
  import clkdiv_pkg::*;
#(
  parameter int unsigned N_DIV   = 9,
  parameter int unsigned RATIO_W = 5
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           req_i,
  input  logic                           we_i,
  input  logic [ADDR_W-1:0]              addr_i,
  input  logic [DATA_W-1:0]              wdata_i,
  output logic [DATA_W-1:0]              rdata_o,
  input  logic                           busy_i,
  output logic                           go_o,
  output logic [N_DIV-1:0][RATIO_W-1:0]  shadow_o,
  output logic [N_DIV-1:0]               en_o
);
  logic                 wr;
  logic [N_DIV-1:0]     hit;
  logic [N_DIV-1:0][RATIO_W-1:0] shadow_q;
  logic [N_DIV-1:0]     en_q;

  assign wr = req_i & we_i;

  for (genvar i = 0; i < N_DIV; i++) begin : g_dec
    assign hit[i] = (addr_i == div_addr(i));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        shadow_q[i] <= '0;
        en_q[i]     <= 1'b1;
      end else if (wr && hit[i]) begin
        shadow_q[i] <= wdata_i[RATIO_W-1:0];
        en_q[i]     <= wdata_i[EN_BIT];
      end
    end

    a_r4_shadow_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(wr && hit[i]) |=> $stable(shadow_q[i]));
  end

  assign go_o     = wr && (addr_i == CMD_ADDR) && wdata_i[0];
  assign shadow_o = shadow_q;
  assign en_o     = en_q;

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < N_DIV; i++) begin
      if (hit[i]) begin
        rdata_o[RATIO_W-1:0] = shadow_q[i];
        rdata_o[EN_BIT]      = en_q[i];
      end
    end
    if (addr_i == STA_ADDR) rdata_o[0] = busy_i;
  end

  logic unused_wdata;
  assign unused_wdata = ^{wdata_i[DATA_W-1:EN_BIT+1], wdata_i[EN_BIT-1:RATIO_W]};
endmodule

// File: rtl/clkdiv_sync.sv
module clkdiv_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic go_i,
  output logic busy_o,
  output logic load_o
);
  logic busy_q, done_q;

  // busy: E0 accept, E1 transfer (load_o high before it), E2 clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else if (!busy_q) begin
      busy_q <= go_i;
      done_q <= 1'b0;
    end else if (!done_q) begin
      done_q <= 1'b1;
    end else begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end
  end

  assign busy_o = busy_q;
  assign load_o = busy_q & ~done_q;

  a_r5_go_sets_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (go_i && !busy_o) |=> (busy_o && load_o));
  a_r5_single_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |=> (busy_o && !load_o));
  a_r6_go_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !load_o) |=> !busy_o);
endmodule

// File: rtl/clkdiv_counter.sv
module clkdiv_counter #(
  parameter int unsigned RATIO_W = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [RATIO_W-1:0] ratio_i,
  input  logic               en_i,
  output logic               tick_o
);
  logic [RATIO_W-1:0] cnt_q, act_q;
  logic               wrap;

  assign wrap = (cnt_q == act_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      act_q <= '0;
    end else if (load_i) begin
      cnt_q <= '0;
      act_q <= ratio_i;
    end else begin
      cnt_q <= wrap ? '0 : cnt_q + 1'b1;
    end
  end

  assign tick_o = en_i & wrap;

  a_r3_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= act_q);
  a_r3_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && !load_i) |=> (cnt_q == '0));
  a_r9_load_phase: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (cnt_q == '0 && act_q == $past(ratio_i)));
endmodule

// File: rtl/clkdiv_bank.sv
module clkdiv_bank #(
  parameter int unsigned N_DIV   = 9,   // at most 9 (map has 9 slots)
  parameter int unsigned RATIO_W = 5
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              bus_req_i,
  input  logic                              bus_we_i,
  input  logic [clkdiv_pkg::ADDR_W-1:0]     bus_addr_i,
  input  logic [clkdiv_pkg::DATA_W-1:0]     bus_wdata_i,
  output logic [clkdiv_pkg::DATA_W-1:0]     bus_rdata_o,
  output logic [N_DIV-1:0]                  div_tick_o
);
  logic                          go, busy, load;
  logic [N_DIV-1:0][RATIO_W-1:0] shadow;
  logic [N_DIV-1:0]              en;

  clkdiv_regs #(.N_DIV(N_DIV), .RATIO_W(RATIO_W)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (bus_req_i),
    .we_i     (bus_we_i),
    .addr_i   (bus_addr_i),
    .wdata_i  (bus_wdata_i),
    .rdata_o  (bus_rdata_o),
    .busy_i   (busy),
    .go_o     (go),
    .shadow_o (shadow),
    .en_o     (en)
  );

  clkdiv_sync u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .go_i   (go),
    .busy_o (busy),
    .load_o (load)
  );

  for (genvar i = 0; i < N_DIV; i++) begin : g_div
    clkdiv_counter #(.RATIO_W(RATIO_W)) u_cnt (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .load_i  (load),
      .ratio_i (shadow[i]),
      .en_i    (en[i]),
      .tick_o  (div_tick_o[i])
    );
  end

  a_r7_disabled_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (div_tick_o & ~en) == '0);
endmodule

// File: tb/tb_clkdiv_bank.sv
`timescale 1ns/1ps
module tb_clkdiv_bank;
  localparam int N = 9;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [N-1:0] tick;

  int nchk = 0, nfail = 0;
  logic [31:0] model [N];
  int ratio [N] = '{1, 2, 3, 4, 5, 6, 7, 0, 31};

  always #2 clk = ~clk;

  clkdiv_bank dut (
    .clk_i(clk), .rst_ni(rst_ni), .bus_req_i(req), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .div_tick_o(tick));

  localparam logic [11:0] CMD = 12'h138, STA = 12'h13C;

  function automatic logic [11:0] daddr(int i);
    return (i < 3) ? 12'(12'h118 + 4 * i) : 12'(12'h160 + 4 * (i - 3));
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // call at a negedge; write sampled at the next posedge; returns at the following negedge
  task automatic wr(logic [11:0] a, logic [31:0] d);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    addr = a; #0.5; d = rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int n = 0; n < 16; n++) begin
      rd(STA, s);
      if (s[0] == 1'b0) return;
      @(negedge clk);
    end
  endtask

  task automatic meas(int idx, int exp, string tag);
    int n = 0;
    for (int w = 0; w < 70 && !tick[idx]; w++) @(negedge clk);
    if (exp > 1) begin
      @(negedge clk);
      chk({tag, " width"}, 32'(tick[idx]), 32'd0);
      n = 1;
    end
    do begin @(negedge clk); n++; end while (!tick[idx] && n < 70);
    chk({tag, " period"}, 32'(n), 32'(exp));
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(STA, d); chk("R1 busy", d, 0);
    for (int i = 0; i < N; i++) begin
      rd(daddr(i), d); chk($sformatf("R1 reg%0d", i + 1), d, 32'h8000);
      model[i] = 32'h8000;
    end
    for (int c = 0; c < 3; c++) begin
      chk("R1 ticks", 32'(tick), 32'h1FF); @(negedge clk);
    end
  endtask

  task automatic t_map();
    logic [31:0] d;
    for (int i = 0; i < N; i++) begin
      wr(daddr(i), 32'hFFFF_FFE0 | 32'(ratio[i]));
      model[i] = 32'h8000 | 32'(ratio[i]);
    end
    for (int i = 0; i < N; i++) begin
      rd(daddr(i), d); chk($sformatf("R2 reg%0d", i + 1), d, model[i]);
    end
    for (int c = 0; c < 3; c++) begin
      chk("R4 staged not active", 32'(tick), 32'h1FF); @(negedge clk);
    end
  endtask

  task automatic t_go_align();
    logic [31:0] d;
    int first [N];
    for (int i = 0; i < N; i++) first[i] = -1;
    wr(CMD, 32'h1);                              // k=1 after E0
    rd(STA, d); chk("R5 busy after go", d, 1);
    for (int k = 2; k <= 40; k++) begin
      @(negedge clk);
      if (k == 2) begin rd(STA, d); chk("R5 busy at transfer", d, 1); end
      if (k == 3) begin rd(STA, d); chk("R5 busy cleared", d, 0); end
      for (int i = 0; i < N; i++) if (first[i] < 0 && tick[i]) first[i] = k;
    end
    for (int i = 0; i < N; i++)
      chk($sformatf("R9 first tick div%0d", i + 1), 32'(first[i]), 32'(2 + ratio[i]));
  endtask

  task automatic t_period();
    meas(0, ratio[0] + 1, "R3 div1");
    meas(4, ratio[4] + 1, "R3 div5");
    meas(8, ratio[8] + 1, "R3 div9");
    meas(7, 1, "R3 div8 pass-through");
  endtask

  task automatic t_go_busy();
    logic [31:0] d;
    wr(CMD, 32'h1);
    wr(CMD, 32'h1);                              // lands on transfer edge
    @(negedge clk);
    rd(STA, d); chk("R6 busy clears despite second go", d, 0);
    @(negedge clk);
    rd(STA, d); chk("R6 second go not re-armed", d, 0);
    rd(CMD, d); chk("R6 command reads 0", d, 0);
    meas(1, ratio[1] + 1, "R6 div2 unchanged");
  endtask

  task automatic t_collide();
    logic [31:0] d;
    wr(CMD, 32'h1);
    wr(daddr(0), 32'h8009);                      // same edge as transfer
    model[0] = 32'h8009;
    wait_idle();
    meas(0, ratio[0] + 1, "R4 transfer keeps pre-edge ratio");
    rd(daddr(0), d); chk("R4 new value staged", d, 32'h8009);
    wr(CMD, 32'h1);
    wait_idle();
    meas(0, 10, "R4 next go applies");
    ratio[0] = 9;
  endtask

  task automatic t_enable();
    logic [31:0] d;
    int seen = 0;
    wr(daddr(2), 32'h0000_0003);
    for (int c = 0; c < 20; c++) begin
      if (tick[2]) seen++;
      @(negedge clk);
    end
    chk("R7 disabled low", 32'(seen), 0);
    rd(daddr(2), d); chk("R7 ratio kept", d, 32'h0003);
    wr(daddr(2), 32'h0000_8003);
    meas(2, 4, "R7 re-enabled");
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    logic [11:0] bad [5] = '{12'h124, 12'h150, 12'h15C, 12'h178, 12'h114};
    for (int j = 0; j < 5; j++) wr(bad[j], 32'hFFFF_FFFF);
    for (int j = 0; j < 5; j++) begin
      rd(bad[j], d); chk("R8 unmapped reads 0", d, 0);
    end
    rd(STA, d); chk("R8 no update started", d, 0);
    for (int i = 0; i < N; i++) begin
      rd(daddr(i), d); chk($sformatf("R8 reg%0d intact", i + 1), d, model[i]);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_map();
    t_go_align();
    t_period();
    t_go_busy();
    t_collide();
    model[2] = 32'h8003;
    t_enable();
    t_unmapped();
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog act=hung exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule